// File: doc/BRIEF.md
# Serial Module Bus Host Sequencer

This block is the host end of a four-wire serial link to a plug-in measurement module that sits in a chassis slot. It produces a serial clock, a serial data-out line and an active-low data-select line. It also produces an active-low slot strobe that releases the module's slave select. It samples the module's serial data-in line. A single bit-serial engine runs two kinds of command.

The first is a 32-bit data write. After the write, a fixed deselect sequence lowers the slot strobe and clocks an all-zero slot number into the chassis. The second is a module-ID read of 1 to 32 bits. After the read, the block can clock a 16-bit all-ones parking address.

Every gap between line events is counted in system clock cycles. Each count comes from a time parameter in nanoseconds and the clock period, rounded up. Commands enter through a valid/ready handshake. The block reports a busy level and a one-cycle done pulse, and returns read data right-aligned.

State sequence: `S_IDLE` → `S_LEAD` (select low, lead delay) → `S_LO`/`S_HI` (one bus clock low and high phase per bit). After the last main bit the sequence moves to `S_TRAIL` (trail delay, then select high). From there it goes to `S_GAP` (gap delay) or, after a read without parking, straight to `S_DONE`. From `S_GAP`, a write goes to `S_STB` (strobe low, lead delay) and then clocks the slot bits through `S_LO`/`S_HI`. A read with parking clocks the park bits through `S_LO`/`S_HI` instead. Both then end in `S_DONE` → `S_IDLE`. The slot and park phases are tracked by a phase register (`PH_MAIN`, `PH_SLOT`, `PH_PARK`).

Top module: `smb_host_seq`

## Requirements
- R1: After reset and whenever idle, `bus_clk_o`=1, `sel_data_n_o`=1, `slot_stb_n_o`=1, `bus_mosi_o`=0, `cmd_ready_o`=1, `busy_o`=0 and `done_o`=0.
- R2: A write (`cmd_read_i`=0) clocks out all 32 bits of `cmd_data_i` with the most significant bit first. Each bit is placed on `bus_mosi_o` when `bus_clk_o` falls and holds while the clock is high. For example, 0x830F0000 gives 1,0,0,0,0,0,1,1,...
- R3: From the falling edge of `sel_data_n_o` to the first falling edge of `bus_clk_o` is exactly ceil(T_LEAD_NS / clock period) cycles.
- R4: From the last rising edge of `bus_clk_o` with select low to the rising edge of `sel_data_n_o` is exactly the clock-high width plus ceil(T_TRAIL_NS / clock period) cycles.
- R5: After a write, `slot_stb_n_o` falls exactly ceil(T_GAP_NS / clock period) cycles after `sel_data_n_o` rises. The strobe is never low while select is low.
- R6: While the strobe is low, the block waits the lead delay, then clocks SLOT_W zero bits. The strobe then returns high, and the done pulse marks the end of the write.
- R7: A read (`cmd_read_i`=1) keeps `bus_clk_o` high for the lead delay after select falls. It then gives `cmd_len_i` clock pulses and samples `bus_miso_i` at the end of each high phase. The result is returned with the first sample at bit `cmd_len_i`-1 of `rd_data_o` and zeros above it.
- R8: A read ends by raising `sel_data_n_o` after the trail delay. With `cmd_park_i`=0, no further bus clock edges or strobe activity occur.
- R9: A read with `cmd_park_i`=1 waits the gap delay after select rises, then clocks PARK_W one bits with both select and strobe high.
- R10: Every bus clock low phase lasts at least ceil(SCK_LO_NS / period) cycles, and every high phase inside a transfer lasts at least ceil(SCK_HI_NS / period) cycles.
- R11: `cmd_ready_o` is high only when idle, so a command offered while busy is not taken. `busy_o` rises only on an accepted command. `done_o` is a single-cycle pulse, once per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Sequencer idle, command taken this cycle if valid |
| cmd_read_i | input | 1 | 1 = ID read, 0 = data write |
| cmd_data_i | input | DATA_W | Write word |
| cmd_len_i | input | LEN_W | ID read length in bits, 1..DATA_W |
| cmd_park_i | input | 1 | After a read, clock the parking address |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle end-of-command pulse |
| rd_data_o | output | DATA_W | Right-aligned ID read result |
| bus_clk_o | output | 1 | Serial bus clock |
| bus_mosi_o | output | 1 | Serial data to module |
| bus_miso_i | input | 1 | Serial data from module |
| sel_data_n_o | output | 1 | Active-low data-register select |
| slot_stb_n_o | output | 1 | Active-low slot-select strobe |

## Verification
The bench builds the block with a 10 ns period and the default 180/365/400 ns delays, which gives 18, 37 and 40 cycle gaps. It sets the clock-high width to 70 ns, against a 50 ns low width. With 7 high cycles and 5 low cycles, swapping the two phases, or dropping the high phase from the trail count, changes measured edge distances. The default SLOT_W of 4 and PARK_W of 16 keep the tail phases short enough to count every bit. ID reads of 32 and of 8 bits exercise both the full word and the right-aligned result with its zero upper bits.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_LO,
        S_HI,
        S_TRAIL,
        S_GAP,
        S_STB,
        S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_MAIN,
        PH_SLOT,
        PH_PARK
    } seq_phase_t;

    // Minimum time in ns turned into whole clock cycles, rounded up, at least 1.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ps);
        int unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/smb_delay_timer.sv
module smb_delay_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/smb_shift_reg.sv
module smb_shift_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= load_val_i;
        end else if (shift_i) begin
            q_o <= {q_o[W-2:0], bit_i};
        end
    end
endmodule

// File: rtl/smb_host_seq.sv
module smb_host_seq
    import smb_seq_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 10000,
    parameter int unsigned T_LEAD_NS     = 180,
    parameter int unsigned T_TRAIL_NS    = 365,
    parameter int unsigned T_GAP_NS      = 400,
    parameter int unsigned SCK_LO_NS     = 50,
    parameter int unsigned SCK_HI_NS     = 50,
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned LEN_W         = 6,
    parameter int unsigned SLOT_W        = 4,
    parameter int unsigned PARK_W        = 16,
    parameter int unsigned TMR_W         = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic              cmd_read_i,
    input  logic [DATA_W-1:0] cmd_data_i,
    input  logic [LEN_W-1:0]  cmd_len_i,
    input  logic              cmd_park_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              bus_clk_o,
    output logic              bus_mosi_o,
    input  logic              bus_miso_i,
    output logic              sel_data_n_o,
    output logic              slot_stb_n_o
);
    localparam int unsigned C_LEAD  = ns_to_cycles(T_LEAD_NS, CLK_PERIOD_PS);
    localparam int unsigned C_TRAIL = ns_to_cycles(T_TRAIL_NS, CLK_PERIOD_PS);
    localparam int unsigned C_GAP   = ns_to_cycles(T_GAP_NS, CLK_PERIOD_PS);
    localparam int unsigned C_LO    = ns_to_cycles(SCK_LO_NS, CLK_PERIOD_PS);
    localparam int unsigned C_HI    = ns_to_cycles(SCK_HI_NS, CLK_PERIOD_PS);
    localparam int unsigned CNT_W   = $clog2(DATA_W + 1);
    localparam logic [DATA_W-1:0] PARK_WORD = ~({DATA_W{1'b1}} >> PARK_W);

    seq_state_t state_q, state_nx;
    seq_phase_t phase_q, phase_nx;
    logic              is_rd_q, park_q;
    logic [CNT_W-1:0]  bitcnt_q, bc_val;
    logic              bc_load;
    logic              sh_load, sh_shift;
    logic [DATA_W-1:0] sh_val, sh_q;
    logic              tmr_load, tmr_exp;
    logic [TMR_W-1:0]  tmr_val;
    logic              mosi_nx;

    smb_delay_timer #(.W(TMR_W)) tmr_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load),
        .len_i     (tmr_val),
        .expired_o (tmr_exp)
    );

    smb_shift_reg #(.W(DATA_W)) sh_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (sh_load),
        .load_val_i (sh_val),
        .shift_i    (sh_shift),
        .bit_i      (bus_miso_i),
        .q_o        (sh_q)
    );

    // Next state and datapath controls
    always_comb begin
        state_nx = state_q;
        phase_nx = phase_q;
        sh_load  = 1'b0;
        sh_val   = '0;
        sh_shift = 1'b0;
        bc_load  = 1'b0;
        bc_val   = '0;
        unique case (state_q)
            S_IDLE: if (cmd_valid_i) begin
                state_nx = S_LEAD;
                phase_nx = PH_MAIN;
                sh_load  = 1'b1;
                sh_val   = cmd_read_i ? '0 : cmd_data_i;
                bc_load  = 1'b1;
                bc_val   = cmd_read_i ? CNT_W'(cmd_len_i) : CNT_W'(DATA_W);
            end
            S_LEAD:  if (tmr_exp) state_nx = S_LO;
            S_LO:    if (tmr_exp) state_nx = S_HI;
            S_HI: if (tmr_exp) begin
                sh_shift = 1'b1;
                if (bitcnt_q > CNT_W'(1))  state_nx = S_LO;
                else if (phase_q == PH_MAIN) state_nx = S_TRAIL;
                else                         state_nx = S_DONE;
            end
            S_TRAIL: if (tmr_exp) state_nx = (!is_rd_q || park_q) ? S_GAP : S_DONE;
            S_GAP: if (tmr_exp) begin
                sh_load = 1'b1;
                bc_load = 1'b1;
                if (!is_rd_q) begin
                    state_nx = S_STB;
                    phase_nx = PH_SLOT;
                    bc_val   = CNT_W'(SLOT_W);
                    sh_val   = '0;
                end else begin
                    state_nx = S_LO;
                    phase_nx = PH_PARK;
                    bc_val   = CNT_W'(PARK_W);
                    sh_val   = PARK_WORD;
                end
            end
            S_STB:   if (tmr_exp) state_nx = S_LO;
            S_DONE: begin
                state_nx = S_IDLE;
                phase_nx = PH_MAIN;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // Delay length for the state being entered
    always_comb begin
        tmr_load = (state_nx != state_q);
        unique case (state_nx)
            S_LEAD, S_STB: tmr_val = TMR_W'(C_LEAD);
            S_LO:          tmr_val = TMR_W'(C_LO);
            S_HI:          tmr_val = TMR_W'(C_HI);
            S_TRAIL:       tmr_val = TMR_W'(C_TRAIL);
            S_GAP:         tmr_val = TMR_W'(C_GAP);
            default:       tmr_val = TMR_W'(1);
        endcase
    end

    assign mosi_nx = sh_load  ? sh_val[DATA_W-1] :
                     sh_shift ? sh_q[DATA_W-2]   : sh_q[DATA_W-1];

    // State register and command context
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q   <= S_IDLE;
            phase_q   <= PH_MAIN;
            is_rd_q   <= 1'b0;
            park_q    <= 1'b0;
            bitcnt_q  <= '0;
            rd_data_o <= '0;
        end else begin
            state_q <= state_nx;
            phase_q <= phase_nx;
            if (state_q == S_IDLE && cmd_valid_i) begin
                is_rd_q <= cmd_read_i;
                park_q  <= cmd_park_i;
            end
            if (bc_load)       bitcnt_q <= bc_val;
            else if (sh_shift) bitcnt_q <= bitcnt_q - CNT_W'(1);
            if (state_q == S_TRAIL && tmr_exp && is_rd_q) rd_data_o <= sh_q;
        end
    end

    // Registered bus lines, decoded from the state being entered
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bus_clk_o    <= 1'b1;
            sel_data_n_o <= 1'b1;
            slot_stb_n_o <= 1'b1;
            bus_mosi_o   <= 1'b0;
            done_o       <= 1'b0;
        end else begin
            bus_clk_o    <= (state_nx != S_LO);
            sel_data_n_o <= !(phase_nx == PH_MAIN &&
                              state_nx inside {S_LEAD, S_LO, S_HI, S_TRAIL});
            slot_stb_n_o <= !(phase_nx == PH_SLOT &&
                              state_nx inside {S_STB, S_LO, S_HI});
            done_o       <= (state_nx == S_DONE);
            if (state_nx == S_LO)
                bus_mosi_o <= (is_rd_q && phase_nx == PH_MAIN) ? 1'b0 : mosi_nx;
            else if (state_nx inside {S_IDLE, S_DONE})
                bus_mosi_o <= 1'b0;
        end
    end

    assign cmd_ready_o = (state_q == S_IDLE);
    assign busy_o      = (state_q != S_IDLE);
endmodule

// File: rtl/smb_host_seq_chk.sv
module smb_host_seq_chk #(
    parameter int unsigned LO_CYC = 1,
    parameter int unsigned HI_CYC = 1
) (
    input logic clk_i,
    input logic rst_ni,
    input logic cmd_valid_i,
    input logic cmd_ready_o,
    input logic busy_o,
    input logic done_o,
    input logic bus_clk_o,
    input logic bus_mosi_o,
    input logic sel_data_n_o,
    input logic slot_stb_n_o
);
    logic [15:0] lo_cnt, hi_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else begin
            if (bus_clk_o) lo_cnt <= '0;
            else if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 16'd1;
            if (!bus_clk_o) hi_cnt <= '0;
            else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
        end
    end

    AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_ready_o |-> (bus_clk_o && sel_data_n_o && slot_stb_n_o && !bus_mosi_o)); // R1

    AST_MOSI_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_clk_o && $past(bus_clk_o) && !sel_data_n_o && !$past(sel_data_n_o))
        |-> $stable(bus_mosi_o)); // R2

    AST_STB_NOT_WITH_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !slot_stb_n_o |-> sel_data_n_o); // R5

    AST_SLOT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!slot_stb_n_o && $rose(bus_clk_o)) |-> !bus_mosi_o); // R6

    AST_LO_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bus_clk_o) |-> (lo_cnt >= 16'(LO_CYC))); // R10

    AST_HI_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(bus_clk_o) |-> (hi_cnt >= 16'(HI_CYC))); // R10

    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(cmd_valid_i && cmd_ready_o)); // R11

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R11
endmodule

bind smb_host_seq smb_host_seq_chk #(
    .LO_CYC (C_LO),
    .HI_CYC (C_HI)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_ready_o  (cmd_ready_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .bus_clk_o    (bus_clk_o),
    .bus_mosi_o   (bus_mosi_o),
    .sel_data_n_o (sel_data_n_o),
    .slot_stb_n_o (slot_stb_n_o)
);

// File: tb/smb_host_seq_tb_top.sv
module smb_host_seq_tb_top;
    localparam int PER_PS = 10000;
    localparam int T1 = 180, T2 = 365, T3 = 400, LO_NS = 50, HI_NS = 70;
    localparam int E_D1 = (T1 * 1000 + PER_PS - 1) / PER_PS;
    localparam int E_D2 = (T2 * 1000 + PER_PS - 1) / PER_PS;
    localparam int E_D3 = (T3 * 1000 + PER_PS - 1) / PER_PS;
    localparam int E_LO = (LO_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int E_HI = (HI_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int SLOT_N = 4, PARK_N = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_read = 1'b0, cmd_park = 1'b0;
    logic [31:0] cmd_data = '0;
    logic [5:0]  cmd_len = '0;
    logic cmd_ready, busy, done, bclk, mosi, sel_n, stb_n;
    logic miso = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] id_pat = '0;

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    smb_host_seq #(
        .CLK_PERIOD_PS (PER_PS), .T_LEAD_NS (T1), .T_TRAIL_NS (T2), .T_GAP_NS (T3),
        .SCK_LO_NS (LO_NS), .SCK_HI_NS (HI_NS)
    ) dut_i (
        .clk_i (clk), .rst_ni (rst_n),
        .cmd_valid_i (cmd_valid), .cmd_ready_o (cmd_ready), .cmd_read_i (cmd_read),
        .cmd_data_i (cmd_data), .cmd_len_i (cmd_len), .cmd_park_i (cmd_park),
        .busy_o (busy), .done_o (done), .rd_data_o (rd_data),
        .bus_clk_o (bclk), .bus_mosi_o (mosi), .bus_miso_i (miso),
        .sel_data_n_o (sel_n), .slot_stb_n_o (stb_n)
    );

    // Line monitor, sampled half a cycle after each active edge
    int cyc = 0;
    int t_sel_fall, t_sel_rise, t_stb_fall, t_fall, t_rise, t_last_rise;
    int first_fall, slot_first, park_first;
    int main_n, slot_n, park_n, done_n, fall_idx, min_lo, min_hi;
    logic [31:0] main_bits;
    logic slot_or, park_and;
    logic p_bclk = 1'b1, p_sel = 1'b1, p_stb = 1'b1, p_busy = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (busy && !p_busy) begin
            t_sel_fall = -1; t_sel_rise = -1; t_stb_fall = -1; t_fall = -1;
            t_rise = -1; t_last_rise = -1; first_fall = -1; slot_first = -1;
            park_first = -1; main_n = 0; slot_n = 0; park_n = 0; done_n = 0;
            fall_idx = 0; min_lo = 9999; min_hi = 9999; main_bits = '0;
            slot_or = 1'b0; park_and = 1'b1;
        end
        if (p_sel && !sel_n) t_sel_fall = cyc;
        if (!p_sel && sel_n) t_sel_rise = cyc;
        if (p_stb && !stb_n) t_stb_fall = cyc;
        if (p_bclk && !bclk) begin
            if (t_rise >= 0 && cyc - t_rise < min_hi) min_hi = cyc - t_rise;
            t_fall = cyc;
            if (!sel_n) begin
                if (first_fall < 0) first_fall = cyc;
                if (fall_idx < 32) miso <= id_pat[31 - fall_idx];
                fall_idx++;
            end else if (!stb_n) begin
                if (slot_first < 0) slot_first = cyc;
            end else if (park_first < 0) park_first = cyc;
        end
        if (!p_bclk && bclk) begin
            if (t_fall >= 0 && cyc - t_fall < min_lo) min_lo = cyc - t_fall;
            t_rise = cyc;
            if (!sel_n) begin
                main_bits = {main_bits[30:0], mosi};
                main_n++;
                t_last_rise = cyc;
            end else if (!stb_n) begin
                slot_n++;
                slot_or = slot_or | mosi;
            end else begin
                park_n++;
                park_and = park_and & mosi;
            end
        end
        if (done) done_n++;
        p_bclk = bclk; p_sel = sel_n; p_stb = stb_n; p_busy = busy;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input bit rd, input logic [31:0] data, input int len, input bit park);
        while (!cmd_ready) @(negedge clk);
        cmd_read = rd; cmd_data = data; cmd_len = 6'(len); cmd_park = park;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic test_reset();
        chk(bclk && sel_n && stb_n && !mosi, "R1", "idle lines",
            {bclk, sel_n, stb_n, mosi}, 4'b1110);
        chk(cmd_ready && !busy && !done, "R1", "idle handshake",
            {cmd_ready, busy, done}, 3'b100);
    endtask

    task automatic test_write(input logic [31:0] data);
        issue(1'b0, data, 0, 1'b0);
        chk(main_n == 32, "R2", "write bit count", main_n, 32);
        chk(main_bits == data, "R2", "write bits msb first", main_bits, data);
        chk(first_fall - t_sel_fall == E_D1, "R3", "lead delay", first_fall - t_sel_fall, E_D1);
        chk(t_sel_rise - t_last_rise == E_HI + E_D2, "R4", "trail delay",
            t_sel_rise - t_last_rise, E_HI + E_D2);
        chk(t_stb_fall - t_sel_rise == E_D3, "R5", "gap delay", t_stb_fall - t_sel_rise, E_D3);
        chk(slot_first - t_stb_fall == E_D1, "R6", "strobe to slot clock",
            slot_first - t_stb_fall, E_D1);
        chk(slot_n == SLOT_N && !slot_or, "R6", "zero slot bits", {slot_or, 8'(slot_n)}, SLOT_N);
        chk(stb_n && sel_n && !busy, "R6", "strobe released", {stb_n, sel_n, busy}, 3'b110);
        chk(min_lo >= E_LO && min_hi >= E_HI, "R10", "clock phase widths",
            {16'(min_lo), 16'(min_hi)}, {16'(E_LO), 16'(E_HI)});
        chk(done_n == 1, "R11", "single done pulse", done_n, 1);
    endtask

    task automatic test_read(input logic [31:0] pat, input int len, input bit park);
        logic [31:0] exp;
        id_pat = pat;
        exp = pat >> (32 - len);
        issue(1'b1, 32'h0, len, park);
        chk(main_n == len, "R7", "read pulse count", main_n, len);
        chk(rd_data == exp, "R7", "read data right aligned", rd_data, exp);
        chk(first_fall - t_sel_fall == E_D1, "R7", "clock high through lead",
            first_fall - t_sel_fall, E_D1);
        chk(t_sel_rise - t_last_rise == E_HI + E_D2, "R8", "read trail delay",
            t_sel_rise - t_last_rise, E_HI + E_D2);
        chk(t_stb_fall < 0 && slot_n == 0, "R8", "no strobe after read", slot_n, 0);
        if (!park) begin
            chk(park_n == 0, "R8", "no clocks after read end", park_n, 0);
        end else begin
            chk(park_first - t_sel_rise == E_D3, "R9", "park gap", park_first - t_sel_rise, E_D3);
            chk(park_n == PARK_N && park_and, "R9", "park ones", {park_and, 8'(park_n)},
                {1'b1, 8'(PARK_N)});
        end
        chk(done_n == 1, "R11", "single done pulse", done_n, 1);
    endtask

    task automatic test_busy_hold();
        while (!cmd_ready) @(negedge clk);
        cmd_read = 1'b0; cmd_data = 32'hFFFF_FFFF; cmd_park = 1'b0;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (50) @(negedge clk);
        cmd_read = 1'b1; cmd_len = 6'd8; cmd_valid = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!cmd_ready && busy, "R11", "ready held off while busy", {cmd_ready, busy}, 2'b01);
        end
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        repeat (60) @(negedge clk);
        chk(sel_n && !busy && main_n == 32, "R11", "offered command not taken",
            {sel_n, busy, 8'(main_n)}, {2'b10, 8'd32});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_write(32'h830F_0000);
        test_write(32'h5A3C_96E1);
        test_read(32'hA5C3_1E77, 32, 1'b0);
        test_read(32'h96F0_0000, 8, 1'b1);
        test_busy_hold();
        test_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule